// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs from the oscillator clock and divides it by four to get the conversion clock. One conversion cycle lasts a fixed 4000 conversion counts and has three phases, always in the same order. First the converter zeroes its offsets. Then it integrates the input for exactly 1000 counts. Last, it runs the integrator back to zero with the reference. The block drives four registered, mutually exclusive phase controls to the analog switches. The controls are auto-zero, integrate, de-integrate with positive reference, and de-integrate with negative reference. The integrator, the switches, the reference and the comparator all sit outside the block.

At the last count of integrate, the block samples the comparator to learn the sign of the input. That sign chooses which de-integrate control is raised. The block then counts conversion counts in BCD until the comparator reports that the integrator has crossed zero. That count is the reading, equal to 1000 × Vin/Vref. The reading has three BCD digits plus a leading thousands bit, so it runs up to 1999. It is latched together with a sign and an overrange flag, and a one-cycle strobe marks it. Auto-zero fills whatever time de-integrate leaves over, so every cycle has the same length.

The result leaves through a plain strobe and has no ready input. The conversion timing is fixed by the integration physics and cannot stall, so back-pressure is not possible. Instead, the reading stays stable for a whole conversion cycle, until the next strobe.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held and right after it, only the auto-zero control is high, the strobe is low, and the reading, sign and overrange outputs are 0. The first integrate phase begins 1000 conversion counts (4000 oscillator clocks) after reset is released.
- R2: One conversion count lasts 4 oscillator clocks. Every phase length is a whole number of counts.
- R3: The integrate control stays high for exactly 1000 counts (4000 oscillator clocks).
- R4: De-integrate ends at the first count at which `cmp_pos` differs from the sign latched at the end of integrate. If the comparator already differs at the first count, the reading is 0. A crossing detected after N unchanged counts gives reading N and a de-integrate length of N+1 counts. The strobe rises in the same clock in which auto-zero returns.
- R5: Integrate starts every 4000 counts (16000 oscillator clocks). Auto-zero takes whatever time integrate and de-integrate leave unused.
- R6: The value of `cmp_pos` at the last integrate count selects the reference direction. A value of 1 raises `ph_de_pos` and a value of 0 raises `ph_de_neg`. The selected control is the only one high through de-integrate, and de-integrate always directly follows integrate.
- R7: The reading is BCD. Bits 3:0 hold the units, 7:4 the tens and 11:8 the hundreds. Bit 12 is the thousands digit, which can only be 0 or 1. No nibble ever exceeds 9.
- R8: `rd_neg` equals the inverse of the latched comparator sign, and this holds even when the reading is 0.
- R9: If no crossing has been seen after the count reaches 1999, de-integrate ends after 2000 counts. The reading is then 1999 with `rd_ovr` set. Otherwise `rd_ovr` is 0.
- R10: Exactly one phase control is high in every clock.
- R11: `rd_valid` is high for one clock per conversion. The reading, sign and overrange outputs change only together with it.
- R12: `cmp_pos` has no effect during auto-zero or during integrate before its last count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_pos | input | 1 | Comparator: 1 when the integrator output sits on the positive-input side |
| ph_az | output | 1 | Auto-zero phase control |
| ph_int | output | 1 | Signal integrate phase control |
| ph_de_pos | output | 1 | De-integrate control for a positive input |
| ph_de_neg | output | 1 | De-integrate control for a negative input |
| rd_valid | output | 1 | One-clock strobe for a new reading |
| rd_bcd | output | 13 | Reading: thousands bit, then hundreds, tens and units nibbles |
| rd_neg | output | 1 | Reading is negative |
| rd_ovr | output | 1 | Overrange: no crossing seen within 1999 counts |

## Verification
The hardest situations to produce are the two ends of de-integrate. One is a crossing already present at the first count, which gives a zero reading that must still carry the right sign. The other is a comparator that never crosses, which must stop the count at 1999 and flag overrange. The bench models the comparator as a ramp that changes level a set number of counts after de-integrate starts. It aligns that change to the oscillator clock so the design sees it at one exact count. Directed runs cover zero with each sign, full scale and a crossing that never comes. Seeded random crossing counts and signs fill in between. The comparator is also driven with random values during auto-zero to show it is ignored there.

// File: rtl/ds_pkg.sv
package ds_pkg;

  typedef enum logic [1:0] {
    PH_ZERO  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

endpackage

// File: rtl/ds_prescaler.sv
module ds_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q == PW'(DIV - 1))      cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/ds_bcd_counter.sv
module ds_bcd_counter #(
  parameter int DIGITS = 3,
  localparam int VW = 4 * DIGITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [VW-1:0] value,
  output logic          full
);
  logic [DIGITS:0] carry;
  logic            top_q;

  assign carry[0] = inc;

  genvar i;
  generate
    for (i = 0; i < DIGITS; i++) begin : g_dig
      logic [3:0] d_q;
      assign carry[i+1] = carry[i] && (d_q == 4'd9);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        d_q <= 4'd0;
        else if (clr)      d_q <= 4'd0;
        else if (carry[i]) d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
      end
      assign value[4*i +: 4] = d_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             top_q <= 1'b0;
    else if (clr)           top_q <= 1'b0;
    else if (carry[DIGITS]) top_q <= 1'b1;
  end

  assign value[VW-1] = top_q;
  assign full        = (value == {1'b1, {DIGITS{4'h9}}});
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
  parameter int PRESCALE = 4,
  parameter int DIGITS   = 3,
  localparam int RW      = 4 * DIGITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_pos,
  output logic          ph_az,
  output logic          ph_int,
  output logic          ph_de_pos,
  output logic          ph_de_neg,
  output logic          rd_valid,
  output logic [RW-1:0] rd_bcd,
  output logic          rd_neg,
  output logic          rd_ovr
);
  import ds_pkg::*;

  localparam int SCALE    = 10 ** DIGITS;
  localparam int INT_CNT  = SCALE;
  localparam int CYCLE    = 4 * SCALE;
  localparam int AZ_START = CYCLE - SCALE;
  localparam int CW       = $clog2(CYCLE);

  logic          tick;
  logic          cnt_clr, cnt_inc, cnt_full;
  logic [RW-1:0] cnt_val;

  phase_e        state_q, state_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          pol_q, pol_d;
  logic          done, over;

  ds_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  ds_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .value (cnt_val),
    .full  (cnt_full)
  );

  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    pol_d   = pol_q;
    done    = 1'b0;
    over    = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (tick) begin
      unique case (state_q)
        PH_ZERO: begin
          if (cyc_q == CW'(CYCLE - 1)) begin
            cyc_d   = '0;
            state_d = PH_INTEG;
          end else begin
            cyc_d = cyc_q + 1'b1;
          end
        end
        PH_INTEG: begin
          cyc_d = cyc_q + 1'b1;
          if (cyc_q == CW'(INT_CNT - 1)) begin
            state_d = PH_DEINT;
            pol_d   = cmp_pos;
            cnt_clr = 1'b1;
          end
        end
        PH_DEINT: begin
          cyc_d = cyc_q + 1'b1;
          if (cmp_pos != pol_q) begin
            done = 1'b1;
          end else if (cnt_full) begin
            done = 1'b1;
            over = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
          if (done) state_d = PH_ZERO;
        end
        default: state_d = PH_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_ZERO;
      cyc_q     <= CW'(AZ_START);
      pol_q     <= 1'b0;
      ph_az     <= 1'b1;
      ph_int    <= 1'b0;
      ph_de_pos <= 1'b0;
      ph_de_neg <= 1'b0;
    end else begin
      state_q   <= state_d;
      cyc_q     <= cyc_d;
      pol_q     <= pol_d;
      ph_az     <= (state_d == PH_ZERO);
      ph_int    <= (state_d == PH_INTEG);
      ph_de_pos <= (state_d == PH_DEINT) &&  pol_d;
      ph_de_neg <= (state_d == PH_DEINT) && !pol_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_bcd   <= '0;
      rd_neg   <= 1'b0;
      rd_ovr   <= 1'b0;
    end else begin
      rd_valid <= done;
      if (done) begin
        rd_bcd <= cnt_val;
        rd_neg <= !pol_q;
        rd_ovr <= over;
      end
    end
  end
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int RW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ph_az,
  input logic          ph_int,
  input logic          ph_de_pos,
  input logic          ph_de_neg,
  input logic          rd_valid,
  input logic [RW-1:0] rd_bcd,
  input logic          rd_neg,
  input logic          rd_ovr
);
  localparam int ND = (RW - 1) / 4;

  function automatic bit nibbles_ok(logic [RW-1:0] v);
    bit ok = 1'b1;
    for (int k = 0; k < ND; k++) if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ph_az, ph_int, ph_de_pos, ph_de_neg}) == 1);

  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable({rd_bcd, rd_neg, rd_ovr}));

  p_bcd_digits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nibbles_ok(rd_bcd));

  p_ovr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ovr |-> (rd_bcd == {1'b1, {ND{4'h9}}}));

  p_de_after_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_de_pos || ph_de_neg) |-> $past(ph_int));

  p_strobe_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ph_az && $past(ph_de_pos || ph_de_neg)));
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ph_az     (ph_az),
  .ph_int    (ph_int),
  .ph_de_pos (ph_de_pos),
  .ph_de_neg (ph_de_neg),
  .rd_valid  (rd_valid),
  .rd_bcd    (rd_bcd),
  .rd_neg    (rd_neg),
  .rd_ovr    (rd_ovr)
);

// File: tb/dual_slope_seq_tb.sv
`timescale 1ns/1ps
module dual_slope_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_pos = 1'b0;
  logic        ph_az, ph_int, ph_de_pos, ph_de_neg;
  logic        rd_valid, rd_neg, rd_ovr;
  logic [12:0] rd_bcd;

  int n_total = 0;
  int n_fail  = 0;
  longint nclk = 0;
  longint last_int_rise = -1;
  logic [12:0] last_bcd = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) nclk++;

  dual_slope_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_pos(cmp_pos),
    .ph_az(ph_az), .ph_int(ph_int), .ph_de_pos(ph_de_pos), .ph_de_neg(ph_de_neg),
    .rd_valid(rd_valid), .rd_bcd(rd_bcd), .rd_neg(rd_neg), .rd_ovr(rd_ovr)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] to_bcd(int v);
    return {(v >= 1000) ? 1'b1 : 1'b0, 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic run_conv(bit pos, int n, bit never);
    int len;
    int de_len;
    logic [12:0] exp;
    while (!ph_int) @(negedge clk);
    // R12: random comparator values during auto-zero left the held reading alone
    check(rd_bcd == last_bcd, "R12 reading held through auto-zero", rd_bcd, last_bcd);
    if (last_int_rise >= 0)
      check(nclk - last_int_rise == 16000, "R5 cycle length", nclk - last_int_rise, 16000);
    last_int_rise = nclk;
    cmp_pos = pos;
    len = 0;
    while (ph_int) begin len++; @(negedge clk); end
    check(len == 4000, "R3 R2 integrate length", len, 4000);
    check(ph_de_pos == pos && ph_de_neg == !pos, "R6 reference direction",
          {ph_de_pos, ph_de_neg}, {pos, !pos});
    if (!never && n == 0) cmp_pos = !pos;
    de_len = 0;
    while (!rd_valid) begin
      de_len++;
      @(negedge clk);
      if (!never && de_len == 4 * n) cmp_pos = !pos;
    end
    if (never) begin
      check(de_len == 8000, "R9 overrange length", de_len, 8000);
      exp = 13'h1999;
    end else begin
      check(de_len == 4 * (n + 1), "R4 de-integrate length", de_len, 4 * (n + 1));
      exp = to_bcd(n);
    end
    check(ph_az, "R4 auto-zero with strobe", ph_az, 1);
    check(rd_bcd == exp, "R4 R7 reading", rd_bcd, exp);
    check(rd_neg == !pos, "R8 sign", rd_neg, !pos);
    check(rd_ovr == never, "R9 overrange flag", rd_ovr, never);
    last_bcd = exp;
    cmp_pos = 1'($urandom);
    @(negedge clk);
    check(!rd_valid, "R11 one-cycle strobe", rd_valid, 0);
    for (int k = 0; k < 50; k++) begin
      cmp_pos = 1'($urandom);
      @(negedge clk);
    end
    check(rd_bcd == exp && !rd_valid, "R11 R12 reading held", rd_bcd, exp);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd2024));
    @(negedge clk);
    check(ph_az && !ph_int && !ph_de_pos && !ph_de_neg, "R1 reset phase",
          {ph_az, ph_int, ph_de_pos, ph_de_neg}, 4'b1000);
    check(!rd_valid && rd_bcd == 0 && !rd_neg && !rd_ovr, "R1 reset outputs",
          {rd_valid, rd_bcd, rd_neg, rd_ovr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    do begin
      cmp_pos = 1'($urandom);
      @(negedge clk);
      cnt++;
    end while (!ph_int);
    check(cnt == 4000, "R1 first integrate delay", cnt, 4000);
    run_conv(1'b1, 0, 1'b0);     // zero, positive
    run_conv(1'b0, 0, 1'b0);     // zero, negative
    run_conv(1'b1, 1999, 1'b0);  // full scale
    run_conv(1'b0, 0, 1'b1);     // no crossing: overrange
    run_conv(1'b1, 1, 1'b0);
    run_conv(1'b0, 999, 1'b0);   // decade carry boundary
    for (int r = 0; r < 3; r++) run_conv(1'($urandom), int'($urandom % 1999), 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule